// File: doc/BRIEF.md
# Sampler View Dimension Query Unit

This block answers a size query against a bound texture view. A query carries an unsigned mip level and a four-bit lane write mask. The view descriptor is presented beside it: the kind of view, the base width, height and depth, the array layer count and the number of mip levels. One clock later the block presents a four-lane result. The lanes are the width, the height, the depth or layer count, and the mip level count. The result comes with a one-cycle valid pulse.

The result lanes form a destination register. A lane whose mask bit is clear keeps the value it held before the query. Sizes are given in texels at the requested level. A level at or beyond the view's mip count yields zero for every size lane, while the count lane still reports the view's true mip count. One-dimensional arrays pack their lanes differently from every other kind of view.

Top module: `svq_top`

## Requirements
- R1: After reset every result lane reads zero and `resValid` is low.
- R2: A query presented with `qryValid` high for one cycle updates the lanes at the next rising edge, and `resValid` is high for exactly that one following cycle.
- R3: A reduced dimension equals max(1, base >> level) for width (every kind), height (2D, 2D array, cube) and depth (3D).
- R4: Lane order is x = width, y = height, z = depth or layer count, w = mip count. `viewType` encodes 0 = 1D, 1 = 2D, 2 = 3D, 3 = 1D array, 4 = 2D array, 5 = cube, and 6 and 7 are unused.
- R5: For a 2D array, lane z carries the layer count unreduced by the level.
- R6: For a 1D array, lane x carries the reduced width, lane y carries the unreduced layer count, and lanes z and w are zero.
- R7: When `mipLevel` is greater than or equal to `mipCount`, lanes x, y and z are zero. Lane w still carries `mipCount`, except for a 1D array, where it is zero.
- R8: Lanes that do not apply to the view kind are zero: y and z for 1D, z for 2D and cube, and x, y and z for unused kinds. The w lane of an unused kind still reports `mipCount`.
- R9: Bit i of `writeMask` (bit 0 = x, bit 3 = w) enables the update of lane i. A lane with a clear bit keeps its previous value.
- R10: While `qryValid` is low, all lanes hold their values and `resValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| qryValid | input | 1 | Query strobe |
| mipLevel | input | LVL_W | Requested mip level, unsigned |
| writeMask | input | 4 | Per-lane update enable |
| viewType | input | 3 | View kind code |
| baseWidth | input | DIM_W | Level-0 width in texels |
| baseHeight | input | DIM_W | Level-0 height in texels |
| baseDepth | input | DIM_W | Level-0 depth in texels |
| arraySize | input | DIM_W | Layer count |
| mipCount | input | LVL_W | Number of mip levels |
| resX | output | DIM_W | Lane x result |
| resY | output | DIM_W | Lane y result |
| resZ | output | DIM_W | Lane z result |
| resW | output | DIM_W | Lane w result |
| resValid | output | 1 | One-cycle result pulse |

## Verification
The sweep crosses all eight kind codes, every level up to two past the mip count, and all sixteen masks. It uses three descriptors, one of which has a zero mip count. A design that clamps the shifted size at zero instead of one shows up at deep levels. A design that reduces the layer count shows the wrong lane z on 2D arrays and the wrong lane y on 1D arrays. A design that forgets the out-of-range rule either reports real sizes or wipes the count lane at levels equal to or above the count. A design that ignores the mask, or treats an off-by-one level as in range, corrupts the lanes that the bench model tracks across queries.

// File: rtl/svq_pkg.sv
package svq_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    VK_LINE     = 3'd0,
    VK_PLANE    = 3'd1,
    VK_VOLUME   = 3'd2,
    VK_LINE_ARR = 3'd3,
    VK_PLANE_ARR= 3'd4,
    VK_CUBE     = 3'd5
  } viewKind_e;

  typedef struct packed {
    logic [LANES-1:0] laneLoad;
    logic             anyLoad;
  } svqStrobe_t;
endpackage

// File: rtl/svq_mip_shrink.sv
module svq_mip_shrink #(
  parameter int DIM_W = 16,
  parameter int LVL_W = 5
) (
  input  logic [DIM_W-1:0] baseSize,
  input  logic [LVL_W-1:0] level,
  output logic [DIM_W-1:0] levelSize
);
  logic [DIM_W-1:0] shifted;
  always_comb begin
    shifted   = baseSize >> level;
    levelSize = (shifted == '0) ? DIM_W'(1) : shifted;
  end
endmodule

// File: rtl/svq_ctrl.sv
module svq_ctrl
  import svq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             qryValid,
  input  logic [LANES-1:0] writeMask,
  output svqStrobe_t       strobe,
  output logic             resValid
);
  always_comb begin
    strobe.anyLoad  = qryValid;
    strobe.laneLoad = qryValid ? writeMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= strobe.anyLoad;
  end

  // R2: an accepted query yields a pulse on the next cycle
  p_pulse_after_query_r2: assert property (@(posedge clk) disable iff (!rstN)
    qryValid |=> resValid);
  // R10: no query, no pulse
  p_no_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !qryValid |=> !resValid);
endmodule

// File: rtl/svq_datapath.sv
module svq_datapath
  import svq_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int LVL_W = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  svqStrobe_t                  strobe,
  input  logic [LVL_W-1:0]            mipLevel,
  input  logic [2:0]                  viewType,
  input  logic [DIM_W-1:0]            baseWidth,
  input  logic [DIM_W-1:0]            baseHeight,
  input  logic [DIM_W-1:0]            baseDepth,
  input  logic [DIM_W-1:0]            arraySize,
  input  logic [LVL_W-1:0]            mipCount,
  output logic [LANES-1:0][DIM_W-1:0] laneQ
);
  localparam int NDIMS = 3;

  logic [NDIMS-1:0][DIM_W-1:0] dimBase;
  logic [NDIMS-1:0][DIM_W-1:0] dimLvl;
  logic [LANES-1:0][DIM_W-1:0] laneD;
  logic [DIM_W-1:0]            countExt;
  logic                        inRange;

  assign dimBase  = {baseDepth, baseHeight, baseWidth};
  assign countExt = DIM_W'(mipCount);
  assign inRange  = mipLevel < mipCount;

  for (genvar g = 0; g < NDIMS; g++) begin : gShrink
    svq_mip_shrink #(.DIM_W(DIM_W), .LVL_W(LVL_W)) uShrink (
      .baseSize (dimBase[g]),
      .level    (mipLevel),
      .levelSize(dimLvl[g])
    );
  end

  always_comb begin
    laneD    = '0;
    laneD[3] = countExt;
    case (viewKind_e'(viewType))
      VK_LINE:      laneD[0] = dimLvl[0];
      VK_PLANE,
      VK_CUBE: begin
        laneD[0] = dimLvl[0];
        laneD[1] = dimLvl[1];
      end
      VK_VOLUME: begin
        laneD[0] = dimLvl[0];
        laneD[1] = dimLvl[1];
        laneD[2] = dimLvl[2];
      end
      VK_LINE_ARR: begin
        laneD[0] = dimLvl[0];
        laneD[1] = arraySize;
        laneD[3] = '0;
      end
      VK_PLANE_ARR: begin
        laneD[0] = dimLvl[0];
        laneD[1] = dimLvl[1];
        laneD[2] = arraySize;
      end
      default: ;
    endcase
    if (!inRange) begin
      laneD[0] = '0;
      laneD[1] = '0;
      laneD[2] = '0;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  laneQ[l] <= '0;
      else if (strobe.laneLoad[l]) laneQ[l] <= laneD[l];
    end
    // R9: an unselected lane keeps its value
    p_lane_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.laneLoad[l] |=> $stable(laneQ[l]));
  end

  // R7: size lanes collapse to zero beyond the last level
  p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneLoad[0] && !inRange) |=> (laneQ[0] == '0));
  // R7: count lane survives an out-of-range level
  p_oor_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneLoad[3] && !inRange && viewType != 3'd3) |=> (laneQ[3] == $past(countExt)));
  // R6: 1D array clears lane z
  p_line_arr_z_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneLoad[2] && viewType == 3'd3) |=> (laneQ[2] == '0));
  // R3: a valid width never reduces to zero
  p_min_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneLoad[0] && inRange && viewType <= 3'd5) |=> (laneQ[0] != '0));
endmodule

// File: rtl/svq_top.sv
module svq_top
  import svq_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qryValid,
  input  logic [LVL_W-1:0] mipLevel,
  input  logic [3:0]       writeMask,
  input  logic [2:0]       viewType,
  input  logic [DIM_W-1:0] baseWidth,
  input  logic [DIM_W-1:0] baseHeight,
  input  logic [DIM_W-1:0] baseDepth,
  input  logic [DIM_W-1:0] arraySize,
  input  logic [LVL_W-1:0] mipCount,
  output logic [DIM_W-1:0] resX,
  output logic [DIM_W-1:0] resY,
  output logic [DIM_W-1:0] resZ,
  output logic [DIM_W-1:0] resW,
  output logic             resValid
);
  svqStrobe_t                  strobe;
  logic [LANES-1:0][DIM_W-1:0] laneQ;

  svq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .qryValid (qryValid),
    .writeMask(writeMask),
    .strobe   (strobe),
    .resValid (resValid)
  );

  svq_datapath #(.DIM_W(DIM_W), .LVL_W(LVL_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mipLevel  (mipLevel),
    .viewType  (viewType),
    .baseWidth (baseWidth),
    .baseHeight(baseHeight),
    .baseDepth (baseDepth),
    .arraySize (arraySize),
    .mipCount  (mipCount),
    .laneQ     (laneQ)
  );

  assign resX = laneQ[0];
  assign resY = laneQ[1];
  assign resZ = laneQ[2];
  assign resW = laneQ[3];
endmodule

// File: tb/svq_top_bench.sv
`timescale 1ns/1ps
module svq_top_bench;
  localparam int DIM_W = 16;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic qryValid = 1'b0;
  logic [LVL_W-1:0] mipLevel = '0;
  logic [3:0] writeMask = '0;
  logic [2:0] viewType = '0;
  logic [DIM_W-1:0] baseWidth = '0, baseHeight = '0, baseDepth = '0, arraySize = '0;
  logic [LVL_W-1:0] mipCount = '0;
  logic [DIM_W-1:0] resX, resY, resZ, resW;
  logic resValid;

  int nChecks = 0;
  int nFails = 0;
  logic [DIM_W-1:0] model [4];
  logic [DIM_W-1:0] lastOut [4];

  always #4 clk = ~clk;

  svq_top #(.DIM_W(DIM_W), .LVL_W(LVL_W)) u_svq_top (
    .clk(clk), .rstN(rstN), .qryValid(qryValid), .mipLevel(mipLevel),
    .writeMask(writeMask), .viewType(viewType), .baseWidth(baseWidth),
    .baseHeight(baseHeight), .baseDepth(baseDepth), .arraySize(arraySize),
    .mipCount(mipCount), .resX(resX), .resY(resY), .resZ(resZ), .resW(resW),
    .resValid(resValid)
  );

  function automatic logic [DIM_W-1:0] outLane(int l);
    case (l)
      0: return resX;
      1: return resY;
      2: return resZ;
      default: return resW;
    endcase
  endfunction

  function automatic logic [DIM_W-1:0] shrink(logic [DIM_W-1:0] b, int lvl);
    logic [DIM_W-1:0] s;
    s = b >> lvl;
    return (s == 0) ? 1 : s;
  endfunction

  // expected fresh value of lane l, from R3..R8
  function automatic logic [DIM_W-1:0] expLane(int l, int t, int lvl, int mc,
      logic [DIM_W-1:0] bw, logic [DIM_W-1:0] bh, logic [DIM_W-1:0] bd, logic [DIM_W-1:0] as);
    logic [DIM_W-1:0] v[4];
    v[0] = 0; v[1] = 0; v[2] = 0; v[3] = DIM_W'(mc);
    case (t)
      0: v[0] = shrink(bw, lvl);
      1, 5: begin v[0] = shrink(bw, lvl); v[1] = shrink(bh, lvl); end
      2: begin v[0] = shrink(bw, lvl); v[1] = shrink(bh, lvl); v[2] = shrink(bd, lvl); end
      3: begin v[0] = shrink(bw, lvl); v[1] = as; v[3] = 0; end
      4: begin v[0] = shrink(bw, lvl); v[1] = shrink(bh, lvl); v[2] = as; end
      default: ;
    endcase
    if (lvl >= mc) begin v[0] = 0; v[1] = 0; v[2] = 0; end
    return v[l];
  endfunction

  function automatic string tagFor(int l, int t, int lvl, int mc, logic m, logic [DIM_W-1:0] e);
    if (!m) return "R9";
    if (lvl >= mc && l < 3) return "R7";
    if (t == 3) return "R6";
    if (e == 0) return "R8";
    if (l == 3) return "R4";
    if (t == 4 && l == 2) return "R5";
    return "R3";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic runQuery(int t, int lvl, int mask, logic [DIM_W-1:0] bw, logic [DIM_W-1:0] bh,
      logic [DIM_W-1:0] bd, logic [DIM_W-1:0] as, int mc);
    logic [DIM_W-1:0] e;
    viewType = 3'(t); mipLevel = LVL_W'(lvl); writeMask = 4'(mask);
    baseWidth = bw; baseHeight = bh; baseDepth = bd; arraySize = as; mipCount = LVL_W'(mc);
    qryValid = 1'b1;
    @(negedge clk);
    qryValid = 1'b0;
    check(resValid === 1'b1, "R2", "valid pulse", int'(resValid), 1);
    for (int l = 0; l < 4; l++) begin
      e = expLane(l, t, lvl, mc, bw, bh, bd, as);
      if (mask[l]) model[l] = e;
      check(outLane(l) === model[l], tagFor(l, t, lvl, mc, mask[l], e),
            $sformatf("lane%0d type%0d lvl%0d mask%0h", l, t, lvl, mask),
            int'(outLane(l)), int'(model[l]));
      lastOut[l] = outLane(l);
    end
    // R10: idle cycle, nothing moves
    @(negedge clk);
    check(resValid === 1'b0, "R2", "pulse one cycle", int'(resValid), 0);
    for (int l = 0; l < 4; l++)
      check(outLane(l) === lastOut[l], "R10", $sformatf("idle hold lane%0d", l),
            int'(outLane(l)), int'(lastOut[l]));
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int l = 0; l < 4; l++) model[l] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(resValid === 1'b0, "R1", "valid in reset", int'(resValid), 0);
    for (int l = 0; l < 4; l++)
      check(outLane(l) === '0, "R1", $sformatf("lane%0d in reset", l), int'(outLane(l)), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      logic [DIM_W-1:0] bw, bh, bd, as;
      int mc;
      case (d)
        0: begin bw = 37;  bh = 20;  bd = 9;  as = 6; mc = 6; end
        1: begin bw = 256; bh = 1;   bd = 64; as = 3; mc = 9; end
        default: begin bw = 5; bh = 300; bd = 2; as = 1; mc = 0; end
      endcase
      for (int t = 0; t < 8; t++)
        for (int lvl = 0; lvl <= mc + 2; lvl++)
          for (int m = 0; m < 16; m++)
            runQuery(t, lvl, m, bw, bh, bd, as, mc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule